// File: doc/BRIEF.md
# Fixed-Direction GPIO Register Block

This block is a general purpose I/O controller reached through a 64-byte I/O window. A base register, written from the configuration side, places the window. Inside the window the host finds four 32-bit registers. A use-select register hands muxed pins back to their native functions. An inversion register sets the active level of each input. A sticky event-status register records input activity. An output-level register drives the output pads.

Each pin has one fixed direction. Pins 0, 1, 3, 4, 6, 7, 8, 11, 12 and 13 are inputs. Pins 16 to 19 are outputs. Every other pin below 20 is absent. Each input passes through a two-flop synchronizer and is XORed with its inversion bit. When the result is active, the status bit at the same index sets.

Some pins are shared with native functions: two request/grant pairs, two interrupt lines and one alert input. When such a pin is claimed, its pad value is passed through to the native side. A claimed grant pad is driven by the native grant signal. The bits of pins 8, 11, 12 and 13 sit in the always-on domain and are cleared only by the always-on reset.

Top module: `gpio_fixdir_regs`

## Requirements
- R1: The window covers io_addr bits [15:6] equal to the base register bits [15:6]. The base register resets to 0x0480 and is loaded from cfg_base_wdata when cfg_base_we is high. Its low six bits are always zero. A write outside the window changes nothing.
- R2: The registers sit at window offsets 0x00 (use-select), 0x04 (inversion), 0x08 (status) and 0x0C (output level). io_rdata is all-ones for an address outside the window or at any other offset, including misaligned ones.
- R3: Only some register bits exist. Use-select bits 0, 1, 3, 4 and 11 exist. Inversion and status bits exist at the input pins 0x039DB. Output-level bits 16 to 19 exist. Every other bit reads zero and ignores writes.
- R4: Input n is active when gpi_pad[n] XOR inversion bit n is 1, so inversion 1 means active low. A pad change is seen in the status register after the third rising clock edge.
- R5: A status bit stays set until the host writes 1 to it at offset 0x08. Writing 0 has no effect. When a clear and an active input meet in the same cycle, the bit stays set.
- R6: Pads 16 to 19 of gpo_pad follow output-level bits 16 to 19 on the cycle after the write. All other gpo_pad bits are 0.
- R7: Use-select bit 0 claims pins 0 and 16, and bit 1 claims pins 1 and 17. While a pair is claimed, gpo_pad[16+p] equals nat_gnt[p] instead of the output-level bit.
- R8: While use-select bit n is 1, status bit n stays clear and nat_in[n] equals gpi_pad[n]. Otherwise nat_in[n] is 0.
- R9: Inversion, status and use-select bits for pins 8, 11, 12 and 13 keep their values through rst_core_n and are cleared by rst_rsm_n. All other state, including the base register, is cleared by rst_core_n.
- R10: After reset, the four registers read zero and gpo_pad is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_core_n | input | 1 | Core-domain reset, active low |
| rst_rsm_n | input | 1 | Always-on domain reset, active low |
| cfg_base_we | input | 1 | Load the window base register |
| cfg_base_wdata | input | 16 | New base address, low 6 bits ignored |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data for io_addr |
| gpi_pad | input | 20 | Input pad levels |
| gpo_pad | output | 20 | Output pad levels |
| nat_in | output | 20 | Claimed input pads passed to native logic |
| nat_gnt | input | 2 | Native grant levels for claimed pairs |

## Verification
The bench builds the block with its default parameters. These give 20 pins, the sparse input and output masks above, the always-on set 8/11/12/13, a window at 0x0480 and pairs at pins 0/16 and 1/17. With these values the bench can probe every absent and wrong-direction bit through the register readback. It can exercise both pair claims on the real grant pads, and mix core and always-on bits in one register so that a core reset has a partial effect to observe. It also moves the base register to a second aligned address, which brings the old-window miss path within reach.

// File: rtl/gpio_fixdir_pkg.sv
package gpio_fixdir_pkg;
  localparam int WIN_BYTES = 64;
  localparam logic [5:0] OFF_USE = 6'h00;
  localparam logic [5:0] OFF_INV = 6'h04;
  localparam logic [5:0] OFF_STS = 6'h08;
  localparam logic [5:0] OFF_LVL = 6'h0C;
endpackage

// File: rtl/gpio_bit_ff.sv
module gpio_bit_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gpio_io_decode.sv
module gpio_io_decode
  import gpio_fixdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_RST = 16'h0480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [ADDR_W-1:0] base_q,
  output logic              sel_use,
  output logic              sel_inv,
  output logic              sel_sts,
  output logic              sel_lvl
);
  localparam int WIN_LSB = $clog2(WIN_BYTES);
  localparam int HI_W    = ADDR_W - WIN_LSB;

  logic [HI_W-1:0]    base_hi, base_hi_n;
  logic [WIN_LSB-1:0] off;
  logic               in_win;
  logic               unused_lo;

  always_comb begin
    base_hi_n = base_hi;
    if (cfg_we) base_hi_n = cfg_wdata[ADDR_W-1:WIN_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_hi <= BASE_RST[ADDR_W-1:WIN_LSB];
    else if (cfg_we) base_hi <= base_hi_n;
  end

  assign unused_lo = ^cfg_wdata[WIN_LSB-1:0];
  assign base_q    = {base_hi, {WIN_LSB{1'b0}}};
  assign in_win    = (io_addr[ADDR_W-1:WIN_LSB] == base_hi);
  assign off       = io_addr[WIN_LSB-1:0];
  assign sel_use   = in_win && (off == OFF_USE);
  assign sel_inv   = in_win && (off == OFF_INV);
  assign sel_sts   = in_win && (off == OFF_STS);
  assign sel_lvl   = in_win && (off == OFF_LVL);
endmodule

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
  parameter int NPINS = 20,
  parameter logic [NPINS-1:0] IN_MASK  = 20'h039DB,
  parameter logic [NPINS-1:0] RSM_MASK = 20'h03900
) (
  input  logic             clk,
  input  logic             rst_core_n,
  input  logic             rst_rsm_n,
  input  logic [NPINS-1:0] pad,
  input  logic [NPINS-1:0] inv_q,
  input  logic [NPINS-1:0] use_q,
  input  logic [NPINS-1:0] clr_v,
  output logic [NPINS-1:0] sts_q,
  output logic [NPINS-1:0] act_v
);
  logic [NPINS-1:0] s1_q, s2_q, set_v, sts_n, sts_en;

  always_comb begin
    act_v  = s2_q ^ inv_q;
    set_v  = act_v & ~use_q & IN_MASK;
    sts_n  = ((sts_q & ~clr_v) | set_v) & ~use_q & IN_MASK;
    sts_en = set_v | clr_v | use_q;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_bit
    gpio_bit_ff u_s1 (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                      .en(1'b1), .d(pad[g] & IN_MASK[g]), .q(s1_q[g]));
    gpio_bit_ff u_s2 (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                      .en(1'b1), .d(s1_q[g]), .q(s2_q[g]));
    gpio_bit_ff u_st (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                      .en(sts_en[g]), .d(sts_n[g]), .q(sts_q[g]));
  end
endmodule

// File: rtl/gpio_fixdir_regs.sv
module gpio_fixdir_regs
  import gpio_fixdir_pkg::*;
#(
  parameter int NPINS  = 20,
  parameter int ADDR_W = 16,
  parameter int REG_W  = 32,
  parameter logic [ADDR_W-1:0] BASE_RST = 16'h0480,
  parameter logic [NPINS-1:0] IN_MASK  = 20'h039DB,
  parameter logic [NPINS-1:0] OUT_MASK = 20'hF0000,
  parameter logic [NPINS-1:0] USE_MASK = 20'h0081B,
  parameter logic [NPINS-1:0] RSM_MASK = 20'h03900,
  parameter int NPAIR    = 2,
  parameter int REQ_BASE = 0,
  parameter int GNT_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              rst_rsm_n,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  io_rdata,
  input  logic [NPINS-1:0]  gpi_pad,
  output logic [NPINS-1:0]  gpo_pad,
  output logic [NPINS-1:0]  nat_in,
  input  logic [NPAIR-1:0]  nat_gnt
);
  localparam int PAD_W = REG_W - NPINS;

  logic [ADDR_W-1:0] base_q;
  logic sel_use, sel_inv, sel_sts, sel_lvl;
  logic we_use, we_inv, we_lvl;
  logic [NPINS-1:0] wd_v, use_d, inv_d, lvl_d, clr_v;
  logic [NPINS-1:0] use_q, inv_q, lvl_q, sts_q, act_v;
  logic [NPINS-1:0] claim_o, gnt_v, rd_vec;
  logic             rd_hit;
  logic             unused_w;

  gpio_io_decode #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) u_dec (
    .clk(clk), .rst_n(rst_core_n), .cfg_we(cfg_base_we), .cfg_wdata(cfg_base_wdata),
    .io_addr(io_addr), .base_q(base_q), .sel_use(sel_use), .sel_inv(sel_inv),
    .sel_sts(sel_sts), .sel_lvl(sel_lvl)
  );

  always_comb begin
    wd_v   = io_wdata[NPINS-1:0];
    we_use = io_wr & sel_use;
    we_inv = io_wr & sel_inv;
    we_lvl = io_wr & sel_lvl;
    use_d  = wd_v & USE_MASK;
    inv_d  = wd_v & IN_MASK;
    lvl_d  = wd_v & OUT_MASK;
    clr_v  = (io_wr & sel_sts) ? (wd_v & IN_MASK) : '0;
  end

  assign unused_w = ^{io_wdata[REG_W-1:NPINS], wd_v & ~(IN_MASK | OUT_MASK | USE_MASK)};

  for (genvar g = 0; g < NPINS; g++) begin : g_reg
    gpio_bit_ff u_use (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                       .en(we_use), .d(use_d[g]), .q(use_q[g]));
    gpio_bit_ff u_inv (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                       .en(we_inv), .d(inv_d[g]), .q(inv_q[g]));
    gpio_bit_ff u_lvl (.clk(clk), .rst_n(RSM_MASK[g] ? rst_rsm_n : rst_core_n),
                       .en(we_lvl), .d(lvl_d[g]), .q(lvl_q[g]));
  end

  gpio_in_stage #(.NPINS(NPINS), .IN_MASK(IN_MASK), .RSM_MASK(RSM_MASK)) u_in (
    .clk(clk), .rst_core_n(rst_core_n), .rst_rsm_n(rst_rsm_n), .pad(gpi_pad),
    .inv_q(inv_q), .use_q(use_q), .clr_v(clr_v), .sts_q(sts_q), .act_v(act_v)
  );

  always_comb begin
    claim_o = '0;
    gnt_v   = '0;
    for (int p = 0; p < NPAIR; p++) begin
      claim_o[GNT_BASE+p] = use_q[REQ_BASE+p];
      gnt_v[GNT_BASE+p]   = nat_gnt[p];
    end
  end

  assign gpo_pad = OUT_MASK & ((claim_o & gnt_v) | (~claim_o & lvl_q));
  assign nat_in  = gpi_pad & use_q & IN_MASK;

  always_comb begin
    rd_hit = 1'b1;
    rd_vec = '0;
    if (sel_use)      rd_vec = use_q;
    else if (sel_inv) rd_vec = inv_q;
    else if (sel_sts) rd_vec = sts_q;
    else if (sel_lvl) rd_vec = lvl_q;
    else              rd_hit = 1'b0;
  end

  assign io_rdata = rd_hit ? {{PAD_W{1'b0}}, rd_vec} : {REG_W{1'b1}};
endmodule

// File: rtl/gpio_fixdir_regs_chk.sv
module gpio_fixdir_regs_chk #(
  parameter int NPINS    = 20,
  parameter int ADDR_W   = 16,
  parameter int REG_W    = 32,
  parameter int REQ_BASE = 0,
  parameter int GNT_BASE = 16
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              rst_rsm_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [REG_W-1:0]  io_wdata,
  input logic [REG_W-1:0]  io_rdata,
  input logic [NPINS-1:0]  gpo_pad,
  input logic [ADDR_W-1:0] base_q,
  input logic [NPINS-1:0]  use_q,
  input logic [NPINS-1:0]  sts_q,
  input logic [NPINS-1:0]  act_v
);
  logic [NPINS-1:0] clr_seen;
  logic             lvl_wr;

  assign clr_seen = (io_wr && io_addr == (base_q + 16'h0008)) ? io_wdata[NPINS-1:0] : '0;
  assign lvl_wr   = io_wr && io_addr == (base_q + 16'h000C);

  // R1
  miss_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_rsm_n)
    (io_addr[ADDR_W-1:6] != base_q[ADDR_W-1:6]) |-> (io_rdata == {REG_W{1'b1}}));

  // R4
  status_sets_chk: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_rsm_n)
    1'b1 |=> (($past(act_v) & ~$past(use_q) & ~sts_q) == '0));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_rsm_n)
    1'b1 |=> (($past(sts_q) & ~$past(clr_seen) & ~$past(use_q) & ~sts_q) == '0));

  // R6
  level_drives_pad_chk: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_rsm_n)
    (lvl_wr && !use_q[REQ_BASE]) |=> (gpo_pad[GNT_BASE] == $past(io_wdata[GNT_BASE])));

  // R8
  claimed_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_rsm_n)
    1'b1 |=> ((sts_q & $past(use_q)) == '0));
endmodule

bind gpio_fixdir_regs gpio_fixdir_regs_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .REG_W(REG_W), .REQ_BASE(REQ_BASE), .GNT_BASE(GNT_BASE)
) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .rst_rsm_n(rst_rsm_n), .io_addr(io_addr),
  .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .gpo_pad(gpo_pad),
  .base_q(base_q), .use_q(use_q), .sts_q(sts_q), .act_v(act_v)
);

// File: tb/gpio_fixdir_regs_tb.sv
module gpio_fixdir_regs_tb;
  localparam logic [15:0] B0 = 16'h0480;
  localparam logic [15:0] B1 = 16'h01C0;

  typedef struct packed {
    logic [5:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{6'h00, 32'hFFFF_FFFF, 32'h0000_081B},
    '{6'h00, 32'h0000_0004, 32'h0000_0000},
    '{6'h00, 32'h0000_0000, 32'h0000_0000},
    '{6'h04, 32'hFFFF_FFFF, 32'h0000_39DB},
    '{6'h04, 32'h0000_0000, 32'h0000_0000},
    '{6'h0C, 32'hFFFF_FFFF, 32'h000F_0000},
    '{6'h0C, 32'h0000_0000, 32'h0000_0000},
    '{6'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    '{6'h0C, 32'h0005_0000, 32'h0005_0000}
  };

  logic clk = 1'b0;
  logic rst_core_n, rst_rsm_n, cfg_base_we, io_wr;
  logic [15:0] cfg_base_wdata, io_addr;
  logic [31:0] io_wdata, io_rdata;
  logic [19:0] gpi_pad, gpo_pad, nat_in;
  logic [1:0]  nat_gnt;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_fixdir_regs u_dut (
    .clk(clk), .rst_core_n(rst_core_n), .rst_rsm_n(rst_rsm_n), .cfg_base_we(cfg_base_we),
    .cfg_base_wdata(cfg_base_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .gpi_pad(gpi_pad), .gpo_pad(gpo_pad), .nat_in(nat_in), .nat_gnt(nat_gnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_core_n = 1'b0; rst_rsm_n = 1'b0; cfg_base_we = 1'b0; cfg_base_wdata = '0;
    io_addr = '0; io_wr = 1'b0; io_wdata = '0; gpi_pad = '0; nat_gnt = '0;
    wait_cyc(3);
    rst_core_n = 1'b1; rst_rsm_n = 1'b1;
    wait_cyc(1);

    // R10 reset state
    rd(B0 + 16'h00, r); chk("R10 use reset", r, 32'h0);
    rd(B0 + 16'h04, r); chk("R10 inv reset", r, 32'h0);
    rd(B0 + 16'h08, r); chk("R10 sts reset", r, 32'h0);
    rd(B0 + 16'h0C, r); chk("R10 lvl reset", r, 32'h0);
    chk("R10 gpo reset", {12'h0, gpo_pad}, 32'h0);

    // R1 / R2 misses
    rd(16'h0000, r);       chk("R1 outside window", r, 32'hFFFF_FFFF);
    rd(B0 + 16'h10, r);    chk("R2 undefined offset", r, 32'hFFFF_FFFF);
    rd(B0 + 16'h02, r);    chk("R2 misaligned offset", r, 32'hFFFF_FFFF);

    // R2 R3 table of write/readback vectors
    foreach (VT[i]) begin
      wr(B0 + {10'h0, VT[i].off}, VT[i].wd);
      rd(B0 + {10'h0, VT[i].off}, r);
      chk($sformatf("R3 vector %0d", i), r, VT[i].exp);
    end

    // R6 pads follow level
    chk("R6 pads after level", {12'h0, gpo_pad}, 32'h0005_0000);
    wr(B0 + 16'h0C, 32'h000A_0000);
    chk("R6 pads second level", {12'h0, gpo_pad}, 32'h000A_0000);
    wr(B0 + 16'h0C, 32'h0);

    // R4 synchronizer latency, active high
    @(negedge clk); gpi_pad[6] = 1'b1;
    @(negedge clk); rd(B0 + 16'h08, r); chk("R4 edge1 clear", r & 32'h40, 32'h0);
    @(negedge clk); rd(B0 + 16'h08, r); chk("R4 edge2 clear", r & 32'h40, 32'h0);
    @(negedge clk); rd(B0 + 16'h08, r); chk("R4 edge3 set", r & 32'h40, 32'h40);

    // R5 set wins while pad still active, then sticky after release
    wr(B0 + 16'h08, 32'h40);
    rd(B0 + 16'h08, r); chk("R5 set beats clear", r & 32'h40, 32'h40);
    gpi_pad[6] = 1'b0; wait_cyc(4);
    rd(B0 + 16'h08, r); chk("R5 sticky", r & 32'h40, 32'h40);
    wr(B0 + 16'h08, 32'h0);
    rd(B0 + 16'h08, r); chk("R5 write zero no effect", r & 32'h40, 32'h40);
    wr(B0 + 16'h08, 32'h40);
    rd(B0 + 16'h08, r); chk("R5 w1c", r & 32'h40, 32'h0);

    // R4 inversion: active low
    wr(B0 + 16'h04, 32'h80); wait_cyc(4);
    rd(B0 + 16'h08, r); chk("R4 active low sets", r & 32'h80, 32'h80);
    gpi_pad[7] = 1'b1; wait_cyc(4);
    wr(B0 + 16'h08, 32'h80);
    rd(B0 + 16'h08, r); chk("R4 inverted high idle", r & 32'h80, 32'h0);
    wr(B0 + 16'h04, 32'h0); gpi_pad[7] = 1'b0;

    // R8 claimed input
    wr(B0 + 16'h00, 32'h8);
    gpi_pad[3] = 1'b1; wait_cyc(5);
    rd(B0 + 16'h08, r); chk("R8 claimed status clear", r & 32'h8, 32'h0);
    chk("R8 nat_in pass", {12'h0, nat_in} & 32'h8, 32'h8);
    wr(B0 + 16'h00, 32'h0); wait_cyc(4);
    chk("R8 nat_in released", {12'h0, nat_in}, 32'h0);
    rd(B0 + 16'h08, r); chk("R8 released sets", r & 32'h8, 32'h8);
    gpi_pad[3] = 1'b0; wait_cyc(4);
    wr(B0 + 16'h08, 32'h8);

    // R7 grant pads
    wr(B0 + 16'h00, 32'h3);
    nat_gnt = 2'b01; #1;
    chk("R7 grant pad follows native", {12'h0, gpo_pad}, 32'h0001_0000);
    wr(B0 + 16'h0C, 32'h0002_0000);
    chk("R7 level ignored while claimed", {12'h0, gpo_pad}, 32'h0001_0000);
    wr(B0 + 16'h00, 32'h0);
    chk("R7 level after release", {12'h0, gpo_pad}, 32'h0002_0000);
    nat_gnt = 2'b00;
    wr(B0 + 16'h0C, 32'h0);

    // R1 move base
    @(negedge clk); cfg_base_we = 1'b1; cfg_base_wdata = B1 | 16'h0005;
    @(negedge clk); cfg_base_we = 1'b0;
    rd(B0 + 16'h04, r); chk("R1 old base misses", r, 32'hFFFF_FFFF);
    wr(B0 + 16'h04, 32'h1);
    wr(B1 + 16'h0C, 32'h0004_0000);
    rd(B1 + 16'h0C, r); chk("R1 new base hits", r, 32'h0004_0000);
    rd(B1 + 16'h04, r); chk("R1 write outside ignored", r, 32'h0);
    wr(B1 + 16'h0C, 32'h0);

    // R9 reset domains
    wr(B1 + 16'h04, 32'h1040);
    wr(B1 + 16'h00, 32'h0801);
    wait_cyc(4);
    @(negedge clk); rst_core_n = 1'b0;
    wait_cyc(2);    rst_core_n = 1'b1;
    wait_cyc(1);
    rd(B0 + 16'h04, r); chk("R9 inv survives core reset", r, 32'h1000);
    rd(B0 + 16'h00, r); chk("R9 use survives core reset", r, 32'h0800);
    rd(B0 + 16'h08, r); chk("R9 sts survives core reset", r & 32'h1000, 32'h1000);
    @(negedge clk); rst_rsm_n = 1'b0;
    wait_cyc(2);    rst_rsm_n = 1'b1;
    wait_cyc(1);
    rd(B0 + 16'h04, r); chk("R9 inv after resume reset", r, 32'h0);
    rd(B0 + 16'h00, r); chk("R9 use after resume reset", r, 32'h0);
    rd(B0 + 16'h08, r); chk("R9 sts after resume reset", r, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule